// File: doc/BRIEF.md
# Keypad-Armed Intruder Alarm Controller

This block is the four-state control core of a home alarm. A keypad front end (outside this block) produces a one-clock pulse on `key_enter` each time the user presses the enter key. An external code checker produces `code_ok`, a level that is only meaningful while `key_enter` is high. When the code is correct and the user presses enter, the controller arms or disarms. If the user makes two wrong attempts in a row while the system is armed, the controller latches an alarm, and only reset clears it.

Once armed, a single wrong entry does not raise the alarm. It moves the controller into a strike state. A correct entry from the strike state still disarms the system. A second wrong entry from the strike state locks the alarm on. The `alarm_on` output is decoded from the state register. The state is also brought out on `arm_state` so that a system can observe which phase the controller is in.

The states and their encodings are as follows:

- OFF = 00, disarmed.
- ARMED = 01, monitoring.
- STRIKE = 10, one wrong entry.
- ALARM = 11, latched.

The transitions are named as follows:

- arm: OFF→ARMED.
- disarm: ARMED→OFF and STRIKE→OFF.
- strike: ARMED→STRIKE.
- trip: STRIKE→ALARM.
- hold: no state change.

Top module: `keypad_alarm_fsm`

## Requirements
- R1: Reset is synchronous and active high. On the first rising edge with `rst` high, `arm_state` becomes 00 (OFF) and `alarm_on` becomes 0. Reset takes priority over every other input.
- R2: In OFF (00), `key_enter`=1 with `code_ok`=1 moves the controller to ARMED (01). `key_enter`=1 with `code_ok`=0 leaves it in OFF.
- R3: In ARMED (01), `key_enter`=1 with `code_ok`=1 returns the controller to OFF (00). `key_enter`=1 with `code_ok`=0 moves it to STRIKE (10).
- R4: In STRIKE (10), `key_enter`=1 with `code_ok`=1 returns the controller to OFF (00). `key_enter`=1 with `code_ok`=0 moves it to ALARM (11).
- R5: While `key_enter`=0, the state does not change, whatever the value of `code_ok`.
- R6: ALARM (11) keeps its state under every combination of `key_enter` and `code_ok` until reset.
- R7: `alarm_on` is 1 exactly when `arm_state` is 11 (ALARM), and 0 in the other three states.
- R8: A reset applied while in ALARM returns the controller to OFF (00) with `alarm_on`=0 after one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to OFF |
| key_enter | input | 1 | One-clock pulse for the enter key |
| code_ok | input | 1 | Result from the code checker; valid when key_enter is high |
| alarm_on | output | 1 | High only in the ALARM state |
| arm_state | output | 2 | Current state: 00 OFF, 01 ARMED, 10 STRIKE, 11 ALARM |

## Verification
Each input combination takes effect at the next rising edge, because `arm_state` is a single register. `alarm_on` is decoded from that register, so every result is due exactly one edge after the stimulus that caused it.

The bench drives each stimulus on a falling edge and lets one rising edge pass. It samples both outputs on the following falling edge. A behavioural reference model is advanced at that same rising edge, and the two are compared on every cycle.

Scripted sequences cover the following cases:

- Wrong-then-correct entry while armed.
- Two wrong entries in a row.
- Inputs applied in ALARM.
- Idle cycles with `code_ok` toggling.
- Reset out of ALARM, including with enter held at the same time.

// File: rtl/keypad_alarm_pkg.sv
package keypad_alarm_pkg;

    localparam int unsigned KA_STATE_W = 2;

    typedef enum logic [KA_STATE_W-1:0] {
        ST_OFF    = 2'b00,
        ST_ARMED  = 2'b01,
        ST_STRIKE = 2'b10,
        ST_ALARM  = 2'b11
    } ka_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_GOOD = 2'b01,
        EV_BAD  = 2'b10
    } ka_event_e;

endpackage

// File: rtl/ka_entry_decode.sv
module ka_entry_decode
    import keypad_alarm_pkg::*;
(
    input  logic      key_enter,
    input  logic      code_ok,
    output ka_event_e entry_ev
);

    // code_ok only counts while the enter pulse is present
    always_comb begin
        if (!key_enter) begin
            entry_ev = EV_NONE;
        end else if (code_ok) begin
            entry_ev = EV_GOOD;
        end else begin
            entry_ev = EV_BAD;
        end
    end

endmodule

// File: rtl/ka_next_state.sv
module ka_next_state
    import keypad_alarm_pkg::*;
(
    input  ka_state_e cur_state,
    input  ka_event_e entry_ev,
    output ka_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_OFF: begin
                if (entry_ev == EV_GOOD) nxt_state = ST_ARMED;      // arm
            end
            ST_ARMED: begin
                if (entry_ev == EV_GOOD)     nxt_state = ST_OFF;    // disarm
                else if (entry_ev == EV_BAD) nxt_state = ST_STRIKE; // strike
            end
            ST_STRIKE: begin
                if (entry_ev == EV_GOOD)     nxt_state = ST_OFF;    // disarm
                else if (entry_ev == EV_BAD) nxt_state = ST_ALARM;  // trip
            end
            ST_ALARM: begin
                nxt_state = ST_ALARM;                               // absorbing
            end
            default: nxt_state = ST_OFF;
        endcase
    end

endmodule

// File: rtl/ka_output_decode.sv
module ka_output_decode
    import keypad_alarm_pkg::*;
(
    input  ka_state_e                cur_state,
    output logic                     alarm_on,
    output logic [KA_STATE_W-1:0]    arm_state
);

    always_comb begin
        arm_state = cur_state;
        unique case (cur_state)
            ST_ALARM: alarm_on = 1'b1;
            default:  alarm_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/keypad_alarm_fsm.sv
module keypad_alarm_fsm
    import keypad_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  key_enter,
    input  logic                  code_ok,
    output logic                  alarm_on,
    output logic [KA_STATE_W-1:0] arm_state
);

    ka_event_e entry_ev;
    ka_state_e cur_state;
    ka_state_e nxt_state;

    ka_entry_decode u_entry (
        .key_enter (key_enter),
        .code_ok   (code_ok),
        .entry_ev  (entry_ev)
    );

    ka_next_state u_next (
        .cur_state (cur_state),
        .entry_ev  (entry_ev),
        .nxt_state (nxt_state)
    );

    // state register: synchronous reset has priority
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_OFF;
        end else begin
            cur_state <= nxt_state;
        end
    end

    ka_output_decode u_out (
        .cur_state (cur_state),
        .alarm_on  (alarm_on),
        .arm_state (arm_state)
    );

endmodule

// File: rtl/keypad_alarm_fsm_chk.sv
module keypad_alarm_fsm_chk
    import keypad_alarm_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  key_enter,
    input logic                  code_ok,
    input logic                  alarm_on,
    input logic [KA_STATE_W-1:0] arm_state
);

    // R1: reset lands in OFF on the following edge
    a_r1_reset_to_off: assert property (@(posedge clk)
        rst |=> (arm_state == 2'b00));

    // R2: correct entry in OFF arms
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (arm_state == 2'b00 && key_enter && code_ok) |=> (arm_state == 2'b01));

    // R3: wrong entry while armed strikes
    a_r3_strike: assert property (@(posedge clk) disable iff (rst)
        (arm_state == 2'b01 && key_enter && !code_ok) |=> (arm_state == 2'b10));

    // R4: second wrong entry trips the alarm
    a_r4_trip: assert property (@(posedge clk) disable iff (rst)
        (arm_state == 2'b10 && key_enter && !code_ok) |=> (arm_state == 2'b11));

    // R5: no enter pulse, no state change
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !key_enter |=> $stable(arm_state));

    // R6: alarm is absorbing
    a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        (arm_state == 2'b11) |=> (arm_state == 2'b11));

    // R7: alarm can only rise out of the strike state
    a_r7_alarm_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_on) |-> ($past(arm_state) == 2'b10));

endmodule

bind keypad_alarm_fsm keypad_alarm_fsm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_enter (key_enter),
    .code_ok   (code_ok),
    .alarm_on  (alarm_on),
    .arm_state (arm_state)
);

// File: tb/keypad_alarm_fsm_bench.sv
module keypad_alarm_fsm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_enter = 1'b0;
    logic       code_ok = 1'b0;
    logic       alarm_on;
    logic [1:0] arm_state;

    int n_cmp  = 0;
    int n_bad  = 0;
    int model  = 0;   // 0 OFF, 1 ARMED, 2 STRIKE, 3 ALARM
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    keypad_alarm_fsm u_keypad_alarm_fsm (
        .clk       (clk),
        .rst       (rst),
        .key_enter (key_enter),
        .code_ok   (code_ok),
        .alarm_on  (alarm_on),
        .arm_state (arm_state)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // behavioural reference step
    function automatic int ref_next(int s, bit r, bit e, bit c);
        if (r) return 0;
        if (!e) return s;
        if (s == 0) return c ? 1 : 0;
        if (s == 1) return c ? 0 : 2;
        if (s == 2) return c ? 0 : 3;
        return 3;
    endfunction

    // drive on falling edge, one rising edge, compare on next falling edge
    task automatic step(input bit r, input bit e, input bit c, input string req);
        rst = r; key_enter = e; code_ok = c;
        @(posedge clk);
        model = ref_next(model, r, e, c);
        @(negedge clk);
        n_cmp = n_cmp + 1;
        if (arm_state != model[1:0]) begin
            n_bad = n_bad + 1;
            $display("FAIL %s state: actual=%0d expected=%0d", req, arm_state, model);
        end
        n_cmp = n_cmp + 1;
        if (alarm_on != (model == 3)) begin
            n_bad = n_bad + 1;
            $display("FAIL %s/R7 alarm: actual=%0b expected=%0b", req, alarm_on, model == 3);
        end
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, "R1");           // reset state
        step(1, 1, 1, "R1");           // reset beats enter
        step(0, 0, 1, "R5");           // idle with code_ok high
        step(0, 0, 0, "R5");
        step(0, 1, 0, "R2");           // wrong entry in OFF stays
        step(0, 1, 1, "R2");           // arm
        step(0, 0, 1, "R5");           // idle while armed
        step(0, 1, 1, "R3");           // disarm
        step(0, 1, 1, "R2");           // arm again
        step(0, 1, 0, "R3");           // strike
        step(0, 0, 1, "R5");           // idle in strike
        step(0, 1, 1, "R4");           // wrong-then-correct -> OFF
        step(0, 1, 1, "R2");
        step(0, 1, 0, "R3");
        step(0, 0, 0, "R5");
        step(0, 1, 0, "R4");           // wrong-wrong -> ALARM
        step(0, 1, 1, "R6");
        step(0, 1, 0, "R6");
        step(0, 0, 1, "R6");
        step(0, 0, 0, "R6");
        step(1, 0, 0, "R8");           // reset out of ALARM
        step(0, 0, 0, "R7");
        step(0, 1, 1, "R2");
        step(0, 1, 0, "R3");
        step(0, 1, 0, "R4");
        step(1, 1, 1, "R8");           // reset with enter held
        step(0, 1, 0, "R2");
        for (int i = 0; i < 24; i++) begin
            step(0, (i % 3) != 0, (i % 5) < 2, "R7");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule